// File: doc/BRIEF.md
# Bus switch control and interrupt register

This block is the register core of a four-channel bus switch. A host writes a channel-enable nibble through a plain parallel register port. Each enable bit drives one channel-select output that closes or opens a downstream branch. Reading the same port returns one status byte. Its lower half holds the current enables. Its upper half is a picture of the four active-low interrupt inputs, taken in the cycle of the read.

The interrupt inputs are first synchronized by two flops. Their OR then drives one wired-low interrupt output, modelled as an output enable: high means the pin is pulled low, and low means the pin is released to high impedance. An interrupt is seen whether or not its channel is enabled. Software can therefore find the interrupting branch by reading, then enable that branch to service it. Inputs that are not used for interrupts may be read as general-purpose inputs through the same status bits.

The port has no back-pressure. A write strobe or read strobe is taken in the cycle it is high, and the block never stalls. Read data is registered: it appears one cycle after the strobe and holds until the next read. A power-on reset and an active-low external reset both clear the block. Either one acts at once when asserted, and its release is synchronized to the clock.

Top module: `bswitch_ctrl`

## Requirements
- R1: While power-on reset is held low, chan_en reads 0, rd_data reads 0 and irq_oe is 0 (output released).
- R2: Driving ext_rst_n low clears chan_en and rd_data without waiting for a clock edge. After release, the block ignores a write that comes in the first clock cycle.
- R3: A write with wr_en high sets chan_en to wr_data[3:0] after the next rising edge. Bit i enables channel i. Bits 7:4 of wr_data are ignored.
- R4: A read with rd_en high loads rd_data after the next rising edge. Bit 4+i is 1 when the synchronized irq_n[i] is low. Bits 3:0 are chan_en.
- R5: rd_data holds its value between reads, even if the interrupt inputs change.
- R6: An interrupt on a channel whose enable is 0 still shows in rd_data and still asserts irq_oe.
- R7: irq_oe is 1 exactly when any synchronized interrupt input is low. A change on irq_n reaches irq_oe after two rising edges.
- R8: Several interrupt bits may be set at once. Active-low inputs 4'b1001 (channels 1 and 2 active) give an upper nibble of 4'b0110.
- R9: When a read and a write happen in the same cycle, the read returns the enables that were in place before the write.
- R10: chan_en does not change in a cycle without a write.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| por_n | input | 1 | Power-on reset, active low |
| ext_rst_n | input | 1 | External reset, active low |
| wr_en | input | 1 | Write strobe |
| wr_data | input | 8 | Write data; only bits 3:0 are used |
| rd_en | input | 1 | Read strobe |
| rd_data | output | 8 | Status byte: {interrupt snapshot, enables} |
| irq_n | input | 4 | Per-channel interrupt inputs, active low |
| chan_en | output | 4 | Channel-select outputs |
| irq_oe | output | 1 | Drive the shared interrupt line low when 1 |

## Verification
Two cases are hardest to bring about from the ports. The first is a status snapshot taken while interrupt inputs change around the read. The second is an interrupt on a channel that is switched off. The stimulus enables channels 0 and 2 only, then raises interrupts on channels 1 and 2, and reads after the synchronizer has settled. It then changes the inputs with no read and checks that rd_data stays the same. Reset release is checked by putting a write on the first edge after ext_rst_n rises, which must be dropped, and a read and a write in the same cycle show that the read sees the enables from before the write.

// File: rtl/bsw_pkg.sv
package bsw_pkg;
  localparam int unsigned CH_DEFAULT = 4;
  localparam int unsigned SYNC_STAGES = 2;

  function automatic logic [2*CH_DEFAULT-1:0] pack_status(
    input logic [CH_DEFAULT-1:0] irq_seen,
    input logic [CH_DEFAULT-1:0] enables
  );
    return {irq_seen, enables};
  endfunction
endpackage

// File: rtl/bsw_sync2.sv
module bsw_sync2 #(
  parameter int unsigned W = 1,
  parameter logic [W-1:0] INIT = '0
) (
  input  logic         clk,
  input  logic         arst_n,
  input  logic [W-1:0] d,
  output logic [W-1:0] q
);
  logic [W-1:0] meta;

  always_ff @(posedge clk or negedge arst_n) begin
    if (!arst_n) begin
      meta <= INIT;
      q    <= INIT;
    end else begin
      meta <= d;
      q    <= meta;
    end
  end
endmodule

// File: rtl/bsw_irq_combine.sv
module bsw_irq_combine #(
  parameter int unsigned NCH = 4
) (
  input  logic [NCH-1:0] irq_sync_n,
  output logic [NCH-1:0] irq_act,
  output logic           irq_oe
);
  for (genvar i = 0; i < NCH; i++) begin : g_ch
    assign irq_act[i] = ~irq_sync_n[i];
  end
  assign irq_oe = |irq_act;
endmodule

// File: rtl/bsw_regs.sv
module bsw_regs #(
  parameter int unsigned NCH = 4
) (
  input  logic           clk,
  input  logic           rst_n,
  input  logic           wr_en,
  input  logic [NCH-1:0] wr_nib,
  input  logic           rd_en,
  input  logic [NCH-1:0] irq_act,
  output logic [NCH-1:0] chan_en,
  output logic [2*NCH-1:0] rd_data
);
  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      chan_en <= '0;
    end else if (wr_en) begin
      chan_en <= wr_nib;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      rd_data <= '0;
    end else if (rd_en) begin
      rd_data <= {irq_act, chan_en};
    end
  end
endmodule

// File: rtl/bswitch_ctrl.sv
module bswitch_ctrl #(
  parameter int unsigned NUM_CH = bsw_pkg::CH_DEFAULT,
  localparam int unsigned DW = 2 * NUM_CH
) (
  input  logic              clk,
  input  logic              por_n,
  input  logic              ext_rst_n,
  input  logic              wr_en,
  input  logic [DW-1:0]     wr_data,
  input  logic              rd_en,
  output logic [DW-1:0]     rd_data,
  input  logic [NUM_CH-1:0] irq_n,
  output logic [NUM_CH-1:0] chan_en,
  output logic              irq_oe
);
  logic              raw_rst_n;
  logic              rst_n_i;
  logic [NUM_CH-1:0] irq_sync_n;
  logic [NUM_CH-1:0] irq_act;
  logic              unused_wr_hi;

  assign raw_rst_n    = por_n & ext_rst_n;
  assign unused_wr_hi = ^wr_data[DW-1:NUM_CH];

  bsw_sync2 #(.W(1), .INIT(1'b0)) u_rst_sync (
    .clk    (clk),
    .arst_n (raw_rst_n),
    .d      (1'b1),
    .q      (rst_n_i)
  );

  bsw_sync2 #(.W(NUM_CH), .INIT({NUM_CH{1'b1}})) u_irq_sync (
    .clk    (clk),
    .arst_n (rst_n_i),
    .d      (irq_n),
    .q      (irq_sync_n)
  );

  bsw_irq_combine #(.NCH(NUM_CH)) u_irq (
    .irq_sync_n (irq_sync_n),
    .irq_act    (irq_act),
    .irq_oe     (irq_oe)
  );

  bsw_regs #(.NCH(NUM_CH)) u_regs (
    .clk     (clk),
    .rst_n   (rst_n_i),
    .wr_en   (wr_en),
    .wr_nib  (wr_data[NUM_CH-1:0]),
    .rd_en   (rd_en),
    .irq_act (irq_act),
    .chan_en (chan_en),
    .rd_data (rd_data)
  );
endmodule

// File: rtl/bswitch_ctrl_checker.sv
module bswitch_ctrl_checker #(
  parameter int unsigned NUM_CH = 4,
  localparam int unsigned DW = 2 * NUM_CH
) (
  input logic              clk,
  input logic              rst_n_i,
  input logic              wr_en,
  input logic [DW-1:0]     wr_data,
  input logic              rd_en,
  input logic [DW-1:0]     rd_data,
  input logic [NUM_CH-1:0] irq_n,
  input logic [NUM_CH-1:0] chan_en,
  input logic              irq_oe
);
  assert_reset_clear_R1: assert property (@(posedge clk)
    !rst_n_i |-> (chan_en == '0 && rd_data == '0));

  assert_write_nibble_R3: assert property (@(posedge clk) disable iff (!rst_n_i)
    wr_en |=> chan_en == $past(wr_data[NUM_CH-1:0]));

  assert_hold_enables_R10: assert property (@(posedge clk) disable iff (!rst_n_i)
    !wr_en |=> $stable(chan_en));

  assert_read_low_nibble_R9: assert property (@(posedge clk) disable iff (!rst_n_i)
    rd_en |=> rd_data[NUM_CH-1:0] == $past(chan_en));

  assert_snapshot_hold_R5: assert property (@(posedge clk) disable iff (!rst_n_i)
    !rd_en |=> $stable(rd_data));

  assert_irq_latency_R7: assert property (@(posedge clk) disable iff (!rst_n_i)
    ($past(rst_n_i, 3) && $past(rst_n_i, 2)) |-> (irq_oe == !(&$past(irq_n, 2))));
endmodule

bind bswitch_ctrl bswitch_ctrl_checker #(.NUM_CH(NUM_CH)) u_checker (
  .clk     (clk),
  .rst_n_i (rst_n_i),
  .wr_en   (wr_en),
  .wr_data (wr_data),
  .rd_en   (rd_en),
  .rd_data (rd_data),
  .irq_n   (irq_n),
  .chan_en (chan_en),
  .irq_oe  (irq_oe)
);

// File: tb/test_bswitch_ctrl.sv
`timescale 1ns/1ps
module test_bswitch_ctrl;
  logic       clk = 1'b0;
  logic       por_n = 1'b0;
  logic       ext_rst_n = 1'b1;
  logic       wr_en = 1'b0;
  logic [7:0] wr_data = '0;
  logic       rd_en = 1'b0;
  logic [7:0] rd_data;
  logic [3:0] irq_n = 4'hF;
  logic [3:0] chan_en;
  logic       irq_oe;

  int checks = 0;
  int fails  = 0;
  logic [7:0] exp_q[$];
  string      tag_q[$];
  logic       rd_fire = 1'b0;
  logic       done = 1'b0;

  always #2.5 clk = ~clk;

  bswitch_ctrl i_bswitch_ctrl (
    .clk(clk), .por_n(por_n), .ext_rst_n(ext_rst_n),
    .wr_en(wr_en), .wr_data(wr_data), .rd_en(rd_en), .rd_data(rd_data),
    .irq_n(irq_n), .chan_en(chan_en), .irq_oe(irq_oe)
  );

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  // monitor: pops one expected item per read strobe
  always @(posedge clk) rd_fire <= rd_en;
  always @(negedge clk) begin
    if (rd_fire) begin
      if (exp_q.size() == 0) begin
        checks++; fails++;
        $display("FAIL scoreboard actual=%h expected=none", rd_data);
      end else begin
        check(tag_q.pop_front(), rd_data, exp_q.pop_front());
      end
    end
  end

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_write(input logic [7:0] d);
    wr_en = 1'b1; wr_data = d;
    cyc(1);
    wr_en = 1'b0;
  endtask

  task automatic do_read(input logic [7:0] exp, input string req);
    exp_q.push_back(exp); tag_q.push_back(req);
    rd_en = 1'b1;
    cyc(1);
    rd_en = 1'b0;
  endtask

  initial begin
    cyc(3);
    check("R1 chan_en", {4'h0, chan_en}, 8'h00);
    check("R1 rd_data", rd_data, 8'h00);
    check("R1 irq_oe", {7'h0, irq_oe}, 8'h00);
    por_n = 1'b1;
    cyc(4);

    do_write(8'hF5);
    check("R3 upper bits ignored", {4'h0, chan_en}, 8'h05);
    do_read(8'h05, "R4 idle read");
    cyc(1);

    irq_n = 4'b1001;          // channels 1,2 active; channel 1 disabled
    cyc(3);
    check("R6 R7 irq_oe on disabled ch", {7'h0, irq_oe}, 8'h01);
    do_read(8'h65, "R8 R6 two bits");
    cyc(1);

    irq_n = 4'hF;
    @(posedge clk); #1;
    check("R7 one edge still set", {7'h0, irq_oe}, 8'h01);
    @(posedge clk); #1;
    check("R7 two edges cleared", {7'h0, irq_oe}, 8'h00);
    cyc(2);

    do_read(8'h05, "R4 cleared read");
    irq_n = 4'h0;
    cyc(4);
    check("R5 snapshot held", rd_data, 8'h05);
    do_read(8'hF5, "R4 all channels");
    cyc(1);

    exp_q.push_back(8'hF5); tag_q.push_back("R9 read before write");
    rd_en = 1'b1; wr_en = 1'b1; wr_data = 8'h0A;
    cyc(1);
    rd_en = 1'b0; wr_en = 1'b0;
    check("R9 write applied", {4'h0, chan_en}, 8'h0A);
    cyc(5);
    check("R10 enables held", {4'h0, chan_en}, 8'h0A);

    #1 ext_rst_n = 1'b0;
    #1;
    check("R2 async clear chan_en", {4'h0, chan_en}, 8'h00);
    check("R2 async clear rd_data", rd_data, 8'h00);
    cyc(2);
    ext_rst_n = 1'b1;
    do_write(8'h03);
    check("R2 write in release window ignored", {4'h0, chan_en}, 8'h00);
    cyc(2);
    do_write(8'h03);
    check("R2 write after release", {4'h0, chan_en}, 8'h03);
    irq_n = 4'hF;
    cyc(3);
    do_read(8'h03, "R4 after reset");
    cyc(2);
    if (exp_q.size() != 0) begin
      checks++; fails++;
      $display("FAIL scoreboard actual=%0d expected=0 pending", exp_q.size());
    end
    done = 1'b1;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      checks++; fails++;
      $display("FAIL watchdog actual=hung expected=done");
      $display("%0d/%0d checks passed", checks - fails, checks);
      $finish;
    end
  end
endmodule